// File: doc/BRIEF.md
# ATM Cell Header Translator

This block sits on one input port of a cell switch, behind the stage that finds cell boundaries and checks the header checksum. It takes a byte-wide stream of 53-byte cells and sorts each one by its header. A cell that arrived with a checksum error is discarded. Management cells and cells on reserved channel numbers go out unchanged, flagged for the control path. All other cells are looked up in a small associative map. The path and channel identifiers are replaced with the values stored in the map, and the checksum byte is computed again over the new header. The cell then leaves with the output port number held in the matching map entry. A cell that matches no entry is discarded and counted.

Two static mode inputs set how the header is read. The layout input picks the user-side layout (4-bit flow-control nibble, 8-bit path identifier) or the network-side layout (12-bit path identifier). The switching-mode input picks path-only translation or path-and-channel translation. The map has 16 entries and a single write port. Each entry holds a valid flag, a lookup key, a replacement path identifier, a replacement channel identifier and an output port.

Incoming cells are 53 bytes on consecutive cycles. Gaps are allowed only between cells. The input side is run by a three-state machine:
- WAIT_SOC waits for a start-of-cell byte.
- HEADER gathers header bytes 0 to 4. The lookup and the decision happen on byte 4.
- PAYLOAD counts the 48 payload bytes.

The transitions are:
- WAIT_SOC to HEADER on a start byte.
- HEADER to PAYLOAD on byte 4.
- PAYLOAD to WAIT_SOC on byte 52.
- Any state to HEADER on a new start byte.

Top module: `cell_hdr_xlat`

## Requirements
- R1: After reset, `out_valid`, `out_sop`, `out_drop` and `out_ctrl` are 0, `miss_count` is 0, and no map entry matches.
- R2: A cell whose start byte carries `in_hec_err`=1 produces no `out_valid` byte and one `out_drop` pulse. `miss_count` does not change.
- R3: A cell whose PTI field has its top bit set (bit 3 of header byte 3) leaves byte for byte unchanged, including its original checksum byte. It leaves with `out_ctrl`=1 and `out_port`=0, whether or not the map holds a match.
- R4: A cell whose 16-bit channel identifier is below 32 is handled as in R3 on every path identifier. Channel 32 is translated normally.
- R5: In path-and-channel mode (`cfg_vc_mode`=1), an entry matches only when both its path key and its channel key equal the header. Both identifiers are then replaced, and `out_port` takes the entry's port.
- R6: In path-only mode (`cfg_vc_mode`=0), only the path key is compared. The path identifier is replaced and the channel identifier passes through unchanged.
- R7: With `cfg_nni`=1, byte 0 and the top nibble of byte 1 form a 12-bit path identifier. The rewritten byte 0 is then the top 8 bits of the new path identifier.
- R8: With `cfg_nni`=0, the top nibble of byte 0 is the flow-control field and the path identifier is 8 bits. Every translated cell leaves with that nibble set to 0000.
- R9: The 3-bit PTI and the CLP bit (byte 3, bits 3:1 and bit 0) of a translated cell equal those of the incoming cell.
- R10: Byte 4 of a translated cell is the CRC-8 of output bytes 0 to 3 XOR 0x55. The CRC uses polynomial x^8+x^2+x+1, starts at 0, and takes the most significant bit first.
- R11: A user cell on a non-reserved channel that matches no entry is discarded (one `out_drop` pulse, no output bytes), and `miss_count` rises by exactly 1.
- R12: `out_sop` appears 5 clock edges after the edge that samples the input start byte. The 53 output bytes follow on consecutive cycles, and back-to-back cells are kept intact.
- R13: An entry written with valid=0 never matches. A write replaces an entry. When several valid entries match, the lowest index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_nni | input | 1 | 1 = network-side layout (12-bit path id), 0 = user-side layout |
| cfg_vc_mode | input | 1 | 1 = path-and-channel translation, 0 = path-only |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | First byte of a cell |
| in_byte | input | 8 | Input cell byte |
| in_hec_err | input | 1 | Header check failed; sampled with the start byte |
| tbl_we | input | 1 | Map write strobe |
| tbl_addr | input | 4 | Map entry index |
| tbl_valid | input | 1 | Valid flag written to the entry |
| tbl_key_vpi | input | 12 | Path identifier key |
| tbl_key_vci | input | 16 | Channel identifier key |
| tbl_new_vpi | input | 12 | Replacement path identifier |
| tbl_new_vci | input | 16 | Replacement channel identifier |
| tbl_port | input | 4 | Output port for the entry |
| out_valid | output | 1 | Output byte valid |
| out_sop | output | 1 | First output byte of a cell |
| out_byte | output | 8 | Output cell byte |
| out_port | output | 4 | Output port tag, valid from `out_sop` through the cell |
| out_ctrl | output | 1 | Cell steered to the control path |
| out_drop | output | 1 | One-cycle pulse where a discarded cell would have started |
| miss_count | output | 16 | Number of lookup misses |

## Verification
The bench focuses on the steering order. It sends a cell that has a checksum error and also matches the map; a design that looked up before discarding would count or forward it. It sends a management cell that also matches; a design that looked up first would rewrite it. It sends channel numbers 31 and 32 to catch an off-by-one in the reserved-range compare. It runs path-only mode with an unrelated channel number, where a design that still compared the channel would miss. It uses the wider network-side path identifier, where a design stuck on the user layout would corrupt byte 0. Finally it sends two cells back to back and checks the full 53-byte image of each cell, its recomputed checksum and its output latency. A decision register that was overwritten too early would tag the first cell with the second cell's header.

// File: rtl/chx_pkg.sv
package chx_pkg;

    localparam int VPI_W     = 12;
    localparam int VCI_W     = 16;
    localparam int CELL_LEN  = 53;
    localparam int HDR_LEN   = 5;
    localparam int RSVD_VCI  = 32;
    localparam logic [7:0] HEC_COSET = 8'h55;
    localparam logic [7:0] HEC_POLY  = 8'h07;

    typedef logic [HDR_LEN-1:0][7:0] hdr_t;

    typedef enum logic [1:0] {
        CK_FWD,
        CK_CTRL,
        CK_DROP
    } cell_kind_e;

    typedef enum logic [1:0] {
        WAIT_SOC,
        HEADER,
        PAYLOAD
    } in_state_e;

    function automatic logic [7:0] hec_of(input logic [31:0] h);
        logic [7:0] crc;
        logic       fb;
        crc = '0;
        for (int i = 31; i >= 0; i--) begin
            fb  = crc[7] ^ h[i];
            crc = {crc[6:0], 1'b0};
            if (fb) crc = crc ^ HEC_POLY;
        end
        return crc ^ HEC_COSET;
    endfunction

endpackage

// File: rtl/chx_delay.sv
module chx_delay #(
    parameter int W     = 10,
    parameter int DEPTH = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [DEPTH-1:0][W-1:0] stg_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q <= '0;
                else        stg_q <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q <= '0;
                else        stg_q <= {stg_q[DEPTH-2:0], d};
            end
        end
    endgenerate

    assign q = stg_q[DEPTH-1];

endmodule

// File: rtl/chx_map.sv
module chx_map
    import chx_pkg::*;
#(
    parameter int N_ENT  = 16,
    parameter int PORT_W = 4,
    localparam int AW    = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic              wr_valid,
    input  logic [VPI_W-1:0]  wr_key_vpi,
    input  logic [VCI_W-1:0]  wr_key_vci,
    input  logic [VPI_W-1:0]  wr_new_vpi,
    input  logic [VCI_W-1:0]  wr_new_vci,
    input  logic [PORT_W-1:0] wr_port,
    input  logic [VPI_W-1:0]  lk_vpi,
    input  logic [VCI_W-1:0]  lk_vci,
    input  logic              lk_vc_mode,
    output logic              hit,
    output logic [VPI_W-1:0]  hit_vpi,
    output logic [VCI_W-1:0]  hit_vci,
    output logic [PORT_W-1:0] hit_port
);

    logic [N_ENT-1:0]  vld_q;
    logic [VPI_W-1:0]  kvpi_q [N_ENT];
    logic [VCI_W-1:0]  kvci_q [N_ENT];
    logic [VPI_W-1:0]  nvpi_q [N_ENT];
    logic [VCI_W-1:0]  nvci_q [N_ENT];
    logic [PORT_W-1:0] port_q [N_ENT];
    logic [N_ENT-1:0]  match;
    logic [AW-1:0]     sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     vld_q <= '0;
        else if (wr_en) vld_q[wr_addr] <= wr_valid;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            kvpi_q[wr_addr] <= wr_key_vpi;
            kvci_q[wr_addr] <= wr_key_vci;
            nvpi_q[wr_addr] <= wr_new_vpi;
            nvci_q[wr_addr] <= wr_new_vci;
            port_q[wr_addr] <= wr_port;
        end
    end

    generate
        for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
            assign match[e] = vld_q[e] && (kvpi_q[e] == lk_vpi) &&
                              (!lk_vc_mode || (kvci_q[e] == lk_vci));
        end
    endgenerate

    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int e = N_ENT - 1; e >= 0; e--) begin
            if (match[e]) begin
                hit = 1'b1;
                sel = AW'(e);
            end
        end
    end

    assign hit_vpi  = nvpi_q[sel];
    assign hit_vci  = nvci_q[sel];
    assign hit_port = port_q[sel];

endmodule

// File: rtl/chx_hdr_build.sv
module chx_hdr_build
    import chx_pkg::*;
#(
    parameter int PORT_W = 4
) (
    input  hdr_t              hb_in,
    input  logic              nni,
    input  logic              vc_mode,
    input  logic              hec_err,
    output logic [VPI_W-1:0]  lk_vpi,
    output logic [VCI_W-1:0]  lk_vci,
    input  logic              map_hit,
    input  logic [VPI_W-1:0]  map_vpi,
    input  logic [VCI_W-1:0]  map_vci,
    input  logic [PORT_W-1:0] map_port,
    output cell_kind_e        kind,
    output logic [PORT_W-1:0] port,
    output logic              miss,
    output hdr_t              hb_out
);

    logic [VCI_W-1:0] new_vci;
    hdr_t             rw;

    assign lk_vpi = nni ? {hb_in[0], hb_in[1][7:4]}
                        : {4'h0, hb_in[0][3:0], hb_in[1][7:4]};
    assign lk_vci = {hb_in[1][3:0], hb_in[2], hb_in[3][7:4]};

    assign new_vci = vc_mode ? map_vci : lk_vci;

    always_comb begin
        rw[0] = nni ? map_vpi[11:4] : {4'h0, map_vpi[7:4]};
        rw[1] = {map_vpi[3:0], new_vci[15:12]};
        rw[2] = new_vci[11:4];
        rw[3] = {new_vci[3:0], hb_in[3][3:0]};
        rw[4] = hec_of({rw[0], rw[1], rw[2], rw[3]});
    end

    always_comb begin
        miss = 1'b0;
        if (hec_err)                     kind = CK_DROP;
        else if (hb_in[3][3])            kind = CK_CTRL;
        else if (lk_vci < VCI_W'(RSVD_VCI)) kind = CK_CTRL;
        else if (!map_hit) begin
            kind = CK_DROP;
            miss = 1'b1;
        end else                         kind = CK_FWD;
    end

    assign port   = (kind == CK_FWD) ? map_port : '0;
    assign hb_out = (kind == CK_FWD) ? rw : hb_in;

endmodule

// File: rtl/cell_hdr_xlat.sv
module cell_hdr_xlat
    import chx_pkg::*;
#(
    parameter int N_ENT  = 16,
    parameter int PORT_W = 4,
    parameter int CNT_W  = 16,
    localparam int AW    = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_nni,
    input  logic              cfg_vc_mode,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic [7:0]        in_byte,
    input  logic              in_hec_err,
    input  logic              tbl_we,
    input  logic [AW-1:0]     tbl_addr,
    input  logic              tbl_valid,
    input  logic [11:0]       tbl_key_vpi,
    input  logic [15:0]       tbl_key_vci,
    input  logic [11:0]       tbl_new_vpi,
    input  logic [15:0]       tbl_new_vci,
    input  logic [PORT_W-1:0] tbl_port,
    output logic              out_valid,
    output logic              out_sop,
    output logic [7:0]        out_byte,
    output logic [PORT_W-1:0] out_port,
    output logic              out_ctrl,
    output logic              out_drop,
    output logic [CNT_W-1:0]  miss_count
);

    localparam int IDX_W = $clog2(CELL_LEN);
    localparam int DLY_W = 10;

    in_state_e        state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [3:0][7:0]  hcap_q;
    logic             err_q;
    logic             soc;
    logic             lk_fire;

    hdr_t              hb_cur, hb_new;
    logic [VPI_W-1:0]  lk_vpi, m_vpi;
    logic [VCI_W-1:0]  lk_vci, m_vci;
    logic              m_hit, b_miss;
    logic [PORT_W-1:0] m_port, b_port;
    cell_kind_e        b_kind;

    cell_kind_e        dkind_q, ckind_q;
    logic [PORT_W-1:0] dport_q;
    hdr_t              dhdr_q, chdr_q;
    logic [IDX_W-1:0]  oidx_q;

    logic [DLY_W-1:0]  tail;
    logic              t_valid, t_sop;
    logic [7:0]        t_byte;

    assign soc     = in_valid && in_sop;
    assign lk_fire = (state_q == HEADER) && in_valid && !in_sop &&
                     (idx_q == IDX_W'(HDR_LEN - 1));

    // input state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WAIT_SOC;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WAIT_SOC: if (soc) state_d = HEADER;
            HEADER:   if (soc) state_d = HEADER;
                      else if (lk_fire) state_d = PAYLOAD;
            PAYLOAD:  if (soc) state_d = HEADER;
                      else if (in_valid && idx_q == IDX_W'(CELL_LEN - 1))
                          state_d = WAIT_SOC;
            default:  state_d = WAIT_SOC;
        endcase
    end

    // header capture and decision
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q      <= '0;
            hcap_q     <= '0;
            err_q      <= 1'b0;
            dkind_q    <= CK_DROP;
            dport_q    <= '0;
            dhdr_q     <= '0;
            miss_count <= '0;
        end else begin
            if (soc) begin
                idx_q     <= IDX_W'(1);
                hcap_q[0] <= in_byte;
                err_q     <= in_hec_err;
            end else if (in_valid && state_q != WAIT_SOC) begin
                idx_q <= idx_q + 1'b1;
                if (state_q == HEADER && idx_q < IDX_W'(HDR_LEN - 1))
                    hcap_q[idx_q[1:0]] <= in_byte;
            end
            if (lk_fire) begin
                dkind_q <= b_kind;
                dport_q <= b_port;
                dhdr_q  <= hb_new;
                if (b_miss) miss_count <= miss_count + 1'b1;
            end
        end
    end

    assign hb_cur = {in_byte, hcap_q[3], hcap_q[2], hcap_q[1], hcap_q[0]};

    chx_map #(.N_ENT(N_ENT), .PORT_W(PORT_W)) i_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (tbl_we),
        .wr_addr    (tbl_addr),
        .wr_valid   (tbl_valid),
        .wr_key_vpi (tbl_key_vpi),
        .wr_key_vci (tbl_key_vci),
        .wr_new_vpi (tbl_new_vpi),
        .wr_new_vci (tbl_new_vci),
        .wr_port    (tbl_port),
        .lk_vpi     (lk_vpi),
        .lk_vci     (lk_vci),
        .lk_vc_mode (cfg_vc_mode),
        .hit        (m_hit),
        .hit_vpi    (m_vpi),
        .hit_vci    (m_vci),
        .hit_port   (m_port)
    );

    chx_hdr_build #(.PORT_W(PORT_W)) i_build (
        .hb_in    (hb_cur),
        .nni      (cfg_nni),
        .vc_mode  (cfg_vc_mode),
        .hec_err  (err_q),
        .lk_vpi   (lk_vpi),
        .lk_vci   (lk_vci),
        .map_hit  (m_hit),
        .map_vpi  (m_vpi),
        .map_vci  (m_vci),
        .map_port (m_port),
        .kind     (b_kind),
        .port     (b_port),
        .miss     (b_miss),
        .hb_out   (hb_new)
    );

    chx_delay #(.W(DLY_W), .DEPTH(HDR_LEN)) i_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({in_valid, soc, in_byte}),
        .q     (tail)
    );

    assign {t_valid, t_sop, t_byte} = tail;

    // output stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ckind_q   <= CK_DROP;
            chdr_q    <= '0;
            oidx_q    <= '0;
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_byte  <= '0;
            out_port  <= '0;
            out_ctrl  <= 1'b0;
            out_drop  <= 1'b0;
        end else if (t_sop) begin
            ckind_q   <= dkind_q;
            chdr_q    <= dhdr_q;
            oidx_q    <= IDX_W'(1);
            out_valid <= (dkind_q != CK_DROP);
            out_sop   <= (dkind_q != CK_DROP);
            out_drop  <= (dkind_q == CK_DROP);
            out_byte  <= dhdr_q[0];
            out_port  <= dport_q;
            out_ctrl  <= (dkind_q == CK_CTRL);
        end else if (t_valid) begin
            if (oidx_q < IDX_W'(CELL_LEN - 1)) oidx_q <= oidx_q + 1'b1;
            out_valid <= (ckind_q != CK_DROP);
            out_sop   <= 1'b0;
            out_drop  <= 1'b0;
            out_byte  <= (oidx_q < IDX_W'(HDR_LEN)) ? chdr_q[oidx_q[2:0]] : t_byte;
        end else begin
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_drop  <= 1'b0;
        end
    end

endmodule

// File: rtl/chx_chk.sv
module chx_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_nni,
    input logic             out_valid,
    input logic             out_sop,
    input logic [7:0]       out_byte,
    input logic             out_ctrl,
    input logic             out_drop,
    input logic [CNT_W-1:0] miss_count
);

    // R2
    drop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_drop |-> !out_valid);

    // R12
    sop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sop |-> out_valid);

    // R12
    cell_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sop) |-> $past(out_valid));

    // R8
    gfc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sop && !out_ctrl && !cfg_nni) |-> (out_byte[7:4] == 4'h0));

    // R11
    miss_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_count - $past(miss_count)) <= CNT_W'(1));

endmodule

bind cell_hdr_xlat chx_chk #(.CNT_W(CNT_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_nni    (cfg_nni),
    .out_valid  (out_valid),
    .out_sop    (out_sop),
    .out_byte   (out_byte),
    .out_ctrl   (out_ctrl),
    .out_drop   (out_drop),
    .miss_count (miss_count)
);

// File: tb/test_cell_hdr_xlat.sv
module test_cell_hdr_xlat;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_nni = 1'b0, cfg_vc_mode = 1'b1;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_hec_err = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        tbl_we = 1'b0, tbl_valid = 1'b0;
    logic [3:0]  tbl_addr = '0, tbl_port = '0;
    logic [11:0] tbl_key_vpi = '0, tbl_new_vpi = '0;
    logic [15:0] tbl_key_vci = '0, tbl_new_vci = '0;
    logic        out_valid, out_sop, out_ctrl, out_drop;
    logic [7:0]  out_byte;
    logic [3:0]  out_port;
    logic [15:0] miss_count;

    int n_vec = 0, n_bad = 0;
    int cyc = 0, in_edge = 0, sop_cyc = 0;
    int cap_n = 0, sop_seen = 0, drop_seen = 0, vbytes = 0;
    logic [7:0] cap [64];
    logic [3:0] cap_port;
    logic       cap_ctrl;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cell_hdr_xlat i_cell_hdr_xlat (.*);

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_drop) drop_seen++;
            if (out_valid) begin
                vbytes++;
                if (out_sop) begin
                    cap_n = 0; sop_seen++; sop_cyc = cyc;
                    cap_port = out_port; cap_ctrl = out_ctrl;
                end
                if (cap_n < 64) cap[cap_n] = out_byte;
                cap_n++;
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] tb_hec(input logic [31:0] h);
        logic [7:0] c = 8'h00;
        for (int b = 3; b >= 0; b--) begin
            c = c ^ h[b*8 +: 8];
            for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
        end
        return c ^ 8'h55;
    endfunction

    function automatic logic [31:0] mk(input bit nni, input logic [3:0] gfc,
        input logic [11:0] vpi, input logic [15:0] vci, input logic [2:0] pti, input bit clp);
        return nni ? {vpi, vci, pti, clp} : {gfc, vpi[7:0], vci, pti, clp};
    endfunction

    task automatic wr(input int a, input bit v, input logic [11:0] kp, input logic [15:0] kc,
        input logic [11:0] np, input logic [15:0] nc, input logic [3:0] p);
        @(negedge clk);
        tbl_we = 1; tbl_addr = 4'(a); tbl_valid = v; tbl_key_vpi = kp; tbl_key_vci = kc;
        tbl_new_vpi = np; tbl_new_vci = nc; tbl_port = p;
        @(negedge clk);
        tbl_we = 0;
    endtask

    task automatic send(input logic [31:0] h, input bit err, input logic [7:0] seed, input bit idle);
        for (int k = 0; k < 53; k++) begin
            @(negedge clk);
            in_valid = 1; in_sop = (k == 0); in_hec_err = (k == 0) ? err : 1'b0;
            if (k == 0) in_edge = cyc + 1;
            in_byte = (k < 4) ? h[(3-k)*8 +: 8] : (k == 4) ? tb_hec(h) : 8'(seed + k);
        end
        @(negedge clk);
        in_valid = 0; in_sop = 0;
        if (idle) repeat (10) @(negedge clk);
    endtask

    task automatic expect_cell(input string req, input logic [31:0] h, input logic [3:0] port,
        input bit ctrl, input logic [7:0] hec, input logic [7:0] seed);
        int bad = 0;
        for (int k = 0; k < 53; k++) begin
            logic [7:0] e;
            e = (k < 4) ? h[(3-k)*8 +: 8] : (k == 4) ? hec : 8'(seed + k);
            if (cap[k] !== e) bad++;
        end
        chk({req, " byte count"}, cap_n, 53);
        chk({req, " byte mismatches"}, bad, 0);
        chk({req, " port"}, cap_port, port);
        chk({req, " ctrl flag"}, cap_ctrl, ctrl);
    endtask

    task automatic t_reset;
        chk("R1 out_valid", out_valid, 0);
        chk("R1 out_drop", out_drop, 0);
        chk("R1 out_ctrl", out_ctrl, 0);
        chk("R1 miss_count", miss_count, 0);
    endtask

    task automatic t_vpvc_uni;
        logic [31:0] o;
        cfg_nni = 0; cfg_vc_mode = 1;
        wr(3, 1, 12'h012, 16'h0100, 12'h0A5, 16'h0456, 4'd7);
        sop_seen = 0;
        send(mk(0, 4'hF, 12'h012, 16'h0100, 3'b010, 1), 0, 8'h10, 1);
        o = mk(0, 4'h0, 12'h0A5, 16'h0456, 3'b010, 1);
        expect_cell("R5 R8 R9 R10 uni translate", o, 4'd7, 0, tb_hec(o), 8'h10);
        chk("R12 latency", sop_cyc - in_edge, 5);
    endtask

    task automatic t_reserved;
        logic [31:0] h;
        wr(4, 1, 12'h012, 16'd31, 12'h001, 16'h0900, 4'd3);
        wr(5, 1, 12'h012, 16'd32, 12'h002, 16'h0901, 4'd4);
        h = mk(0, 4'h6, 12'h012, 16'd31, 3'b000, 0);
        send(h, 0, 8'h20, 1);
        expect_cell("R4 vci 31 steered", h, 4'd0, 1, tb_hec(h), 8'h20);
        send(mk(0, 4'h6, 12'h012, 16'd32, 3'b001, 0), 0, 8'h30, 1);
        h = mk(0, 4'h0, 12'h002, 16'h0901, 3'b001, 0);
        expect_cell("R4 vci 32 translated", h, 4'd4, 0, tb_hec(h), 8'h30);
    endtask

    task automatic t_mgmt;
        logic [31:0] h;
        h = mk(0, 4'h3, 12'h012, 16'h0100, 3'b101, 1);
        send(h, 0, 8'h40, 1);
        expect_cell("R3 management passthrough", h, 4'd0, 1, tb_hec(h), 8'h40);
    endtask

    task automatic t_hec_err;
        int s0 = sop_seen, d0 = drop_seen, v0 = vbytes;
        logic [15:0] m0 = miss_count;
        send(mk(0, 4'h0, 12'h012, 16'h0100, 3'b000, 0), 1, 8'h50, 1);
        chk("R2 no bytes", vbytes - v0, 0);
        chk("R2 no sop", sop_seen - s0, 0);
        chk("R2 drop pulse", drop_seen - d0, 1);
        chk("R2 miss unchanged", miss_count, m0);
    endtask

    task automatic t_miss;
        int d0 = drop_seen, v0 = vbytes;
        logic [15:0] m0 = miss_count;
        send(mk(0, 4'h0, 12'h077, 16'h0100, 3'b000, 0), 0, 8'h60, 1);
        chk("R11 no bytes", vbytes - v0, 0);
        chk("R11 drop pulse", drop_seen - d0, 1);
        chk("R11 miss +1", miss_count, m0 + 16'd1);
    endtask

    task automatic t_vp_only;
        logic [31:0] o;
        cfg_vc_mode = 0;
        send(mk(0, 4'h9, 12'h012, 16'h0777, 3'b011, 0), 0, 8'h70, 1);
        o = mk(0, 4'h0, 12'h0A5, 16'h0777, 3'b011, 0);
        expect_cell("R6 path-only keeps vci", o, 4'd7, 0, tb_hec(o), 8'h70);
        cfg_vc_mode = 1;
    endtask

    task automatic t_nni;
        logic [31:0] o;
        cfg_nni = 1;
        wr(8, 1, 12'hABC, 16'h0200, 12'h5DE, 16'h0300, 4'd2);
        send(mk(1, 4'h0, 12'hABC, 16'h0200, 3'b110 & 3'b011, 1), 0, 8'h80, 1);
        o = mk(1, 4'h0, 12'h5DE, 16'h0300, 3'b010, 1);
        expect_cell("R7 nni 12-bit vpi", o, 4'd2, 0, tb_hec(o), 8'h80);
        chk("R7 byte0", cap[0], 8'h5D);
        cfg_nni = 0;
    endtask

    task automatic t_table;
        logic [31:0] o;
        logic [15:0] m0;
        wr(1, 1, 12'h044, 16'h0123, 12'h011, 16'h0222, 4'd9);
        wr(6, 1, 12'h044, 16'h0123, 12'h0EE, 16'h0333, 4'd5);
        send(mk(0, 4'h0, 12'h044, 16'h0123, 3'b000, 0), 0, 8'h90, 1);
        o = mk(0, 4'h0, 12'h011, 16'h0222, 3'b000, 0);
        expect_cell("R13 lowest index wins", o, 4'd9, 0, tb_hec(o), 8'h90);
        wr(1, 0, 12'h044, 16'h0123, 12'h011, 16'h0222, 4'd9);
        wr(6, 0, 12'h044, 16'h0123, 12'h0EE, 16'h0333, 4'd5);
        m0 = miss_count;
        send(mk(0, 4'h0, 12'h044, 16'h0123, 3'b000, 0), 0, 8'h95, 1);
        chk("R13 invalid entry misses", miss_count, m0 + 16'd1);
    endtask

    task automatic t_b2b;
        int s0 = sop_seen, v0 = vbytes;
        logic [31:0] o;
        send(mk(0, 4'h0, 12'h012, 16'h0100, 3'b000, 0), 0, 8'hA0, 0);
        send(mk(0, 4'h0, 12'h012, 16'd32, 3'b000, 1), 0, 8'hB0, 1);
        chk("R12 two sops", sop_seen - s0, 2);
        chk("R12 contiguous bytes", vbytes - v0, 106);
        o = mk(0, 4'h0, 12'h002, 16'h0901, 3'b000, 1);
        expect_cell("R12 second cell intact", o, 4'd4, 0, tb_hec(o), 8'hB0);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_vpvc_uni();
        t_reserved();
        t_mgmt();
        t_hec_err();
        t_miss();
        t_vp_only();
        t_nni();
        t_table();
        t_b2b();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule